// File: doc/BRIEF.md
# Four-Channel DMA Register Core

This block holds the programmable state of a four-channel DMA controller. It does not move data itself. Each channel has a 16-bit current address and a 16-bit current count. A byte-wide processor port loads and reads these registers, one byte per access. One byte pointer, shared by every address and count register, chooses which half of the register an access reaches. Separate write strobes load the command byte, a channel's mode, masks and request flags. Three further strobes cause a master clear, clear the byte pointer, or clear all masks. A status read reports the terminal-count and request flags of the four channels, and the read clears the terminal-count flags.

A bus sequencer outside this block asks for transfers on a separate port. It gives a channel number and a direction. In the same cycle the core returns either the address to use or a not-available flag. On the next clock edge it moves the address, decrements the count, and reloads the channel from its base copies when the channel has autoinitialise set and reaches terminal count. The command byte, the channel masks and each channel's operating mode are brought out for that sequencer to use.

Top module: `dmac_core`

## Requirements
- R1: A byte pointer selects the byte for every address and count access. It reads low (0) after reset, master clear or `ptr_clr`, and those clears take priority over a toggle. Each `cpu_wr` or `cpu_rd` reaches the low byte when the pointer is 0 and the high byte when it is 1, then toggles the pointer. `cpu_ofs[2:1]` picks the channel and `cpu_ofs[0]` picks count (1) or address (0). A read returns the selected byte on `cpu_rdata` in the same cycle.
- R2: Each write to a current register also writes the same merged 16-bit value into that channel's base copy.
- R3: A single-mask write sets channel `cpu_wdata[1:0]`'s mask to `cpu_wdata[2]`. An all-mask write sets channel i's mask to `cpu_wdata[i]` for i = 0..3. `mask_clr` clears all four masks. Masks appear on `chan_mask` after the clock edge.
- R4: A request write sets channel `cpu_wdata[1:0]`'s request flag to `cpu_wdata[2]`. The request flags show in status bits 7:4, channel 0 in bit 4.
- R5: A mode write goes to channel `cpu_wdata[1:0]`. It stores the transfer type from bits 3:2 (0 verify, 1 write, 2 read, 3 invalid), autoinitialise from bit 4, decrement from bit 5 and the operating mode from bits 7:6. The operating mode appears on `chan_opm[2i+1:2i]`. A write request is accepted only on a channel of type 1 and a read request only on a channel of type 2. Otherwise `xfer_na` is 1, `xfer_addr` is 0 and no channel changes.
- R6: An accepted request puts the channel's current address on `xfer_addr` with `xfer_na` at 0 in the same cycle. At the next edge the address moves by +1, or by -1 when decrement is set, and the count drops by 1. Both wrap modulo 2^16.
- R7: A transfer that takes the count from 0 to 0xFFFF sets the channel's terminal-count flag. `stat_rd` returns the terminal-count flags in bits 3:0 and clears them at the next edge. A flag set by a transfer in the same cycle as the read stays set.
- R8: When a channel with autoinitialise set reaches terminal count, its current address and count take their base values at that same edge instead of stepping.
- R9: Reset and master clear both set every mask and every terminal-count flag, clear every request flag and return the byte pointer to low. Reset also clears the command byte, all modes and all address and count registers.
- R10: A command write stores `cpu_wdata` and shows it on `ctrl_cmd` after the edge.
- R11: A transfer request is refused (`xfer_na` = 1, no channel changes) in any cycle where a register-write strobe or a clear strobe is active. Only `cpu_rd` and `stat_rd` may share a cycle with an accepted transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Write one byte of an address or count register |
| cpu_rd | input | 1 | Read one byte of an address or count register |
| cpu_ofs | input | 3 | Register select: channel in bits 2:1, count/address in bit 0 |
| cpu_wdata | input | 8 | Write data for every write strobe |
| cpu_rdata | output | 8 | Read data (register byte or status) |
| cmd_wr | input | 1 | Command byte write |
| mode_wr | input | 1 | Mode write |
| smask_wr | input | 1 | Single-channel mask write |
| amask_wr | input | 1 | All-channel mask write |
| req_wr | input | 1 | Request flag write |
| stat_rd | input | 1 | Status read (clears terminal-count flags) |
| mclr | input | 1 | Master clear |
| ptr_clr | input | 1 | Byte pointer clear |
| mask_clr | input | 1 | Clear all masks |
| xfer_req | input | 1 | Transfer address request |
| xfer_chan | input | 2 | Channel of the transfer request |
| xfer_is_wr | input | 1 | 1 = write transfer, 0 = read transfer |
| xfer_addr | output | 16 | Address for an accepted transfer, else 0 |
| xfer_na | output | 1 | Request not accepted |
| ctrl_cmd | output | 8 | Stored command byte |
| chan_mask | output | 4 | Per-channel mask flags |
| chan_opm | output | 8 | Per-channel operating mode, two bits per channel |

## Verification
The bench goes after the count wrap from 0 to 0xFFFF. A design that tested for 1, or for the count after it drops, would raise terminal count one transfer early or late. With autoinitialise set, the same error would reload the channel at the wrong edge, and the bench catches it from the address sequence that follows the reload. The bench also reads status in the same cycle as a terminal-count transfer; a design that lets the clear win there drops the event. It pairs transfers with register strobes and with mismatched transfer types to catch a design that steps a channel it should leave alone. Long random runs of byte accesses expose a pointer that is kept per register, or that does not toggle on reads.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  localparam int unsigned NCH    = 4;
  localparam int unsigned CHW    = $clog2(NCH);
  localparam int unsigned REG_W  = 16;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    XT_VERIFY  = 2'd0,
    XT_WRITE   = 2'd1,
    XT_READ    = 2'd2,
    XT_INVALID = 2'd3
  } xfer_type_e;

  typedef enum logic [1:0] {
    OPM_DEMAND  = 2'd0,
    OPM_SINGLE  = 2'd1,
    OPM_BLOCK   = 2'd2,
    OPM_CASCADE = 2'd3
  } op_mode_e;

  // Field order follows the mode byte, bits 7:2.
  typedef struct packed {
    op_mode_e   opm;
    logic       dec;
    logic       autoinit;
    xfer_type_e xt;
  } mode_t;

  function automatic logic [REG_W-1:0] byte_merge(input logic [REG_W-1:0] w,
                                                  input logic hi,
                                                  input logic [BYTE_W-1:0] b);
    return hi ? {b, w[BYTE_W-1:0]} : {w[REG_W-1:BYTE_W], b};
  endfunction

  function automatic logic [BYTE_W-1:0] byte_pick(input logic [REG_W-1:0] w,
                                                  input logic hi);
    return hi ? w[REG_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction

  function automatic logic [REG_W-1:0] step_addr(input logic [REG_W-1:0] a,
                                                 input logic dec);
    return dec ? a - 1'b1 : a + 1'b1;
  endfunction

  function automatic logic count_wraps(input logic [REG_W-1:0] c);
    return c == '0;
  endfunction

endpackage

// File: rtl/dmac_byteptr.sv
module dmac_byteptr (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic flip,
  output logic ptr_hi
);

  always_ff @(posedge clk) begin
    if (rst || clr) ptr_hi <= 1'b0;
    else if (flip)  ptr_hi <= ~ptr_hi;
  end

endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mclr,
  input  logic              ld_addr,
  input  logic              ld_cnt,
  input  logic              ld_hi,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              mode_we,
  input  mode_t             mode_d,
  input  logic              mask_we,
  input  logic              mask_d,
  input  logic              mask_all_clr,
  input  logic              req_we,
  input  logic              req_d,
  input  logic              tc_clr,
  input  logic              step,
  output logic [REG_W-1:0]  cur_addr,
  output logic [REG_W-1:0]  cur_cnt,
  output mode_t             mode_q,
  output logic              mask_q,
  output logic              req_q,
  output logic              tc_q,
  output logic              tc_hit
);

  logic [REG_W-1:0] base_addr, base_cnt;
  logic [REG_W-1:0] addr_wr, cnt_wr;
  logic             reload;

  assign addr_wr = byte_merge(cur_addr, ld_hi, wbyte);
  assign cnt_wr  = byte_merge(cur_cnt, ld_hi, wbyte);
  assign tc_hit  = step && count_wraps(cur_cnt);
  assign reload  = tc_hit && mode_q.autoinit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr  <= '0;
      cur_cnt   <= '0;
      base_addr <= '0;
      base_cnt  <= '0;
    end else begin
      if (ld_addr) begin
        cur_addr  <= addr_wr;
        base_addr <= addr_wr;
      end else if (reload) begin
        cur_addr <= base_addr;
      end else if (step) begin
        cur_addr <= step_addr(cur_addr, mode_q.dec);
      end
      if (ld_cnt) begin
        cur_cnt  <= cnt_wr;
        base_cnt <= cnt_wr;
      end else if (reload) begin
        cur_cnt <= base_cnt;
      end else if (step) begin
        cur_cnt <= cur_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= '0;
    else if (mode_we) mode_q <= mode_d;
  end

  always_ff @(posedge clk) begin
    if (rst || mclr) begin
      mask_q <= 1'b1;
      req_q  <= 1'b0;
      tc_q   <= 1'b1;
    end else begin
      if (mask_all_clr) mask_q <= 1'b0;
      else if (mask_we) mask_q <= mask_d;
      if (req_we)       req_q  <= req_d;
      if (tc_hit)       tc_q   <= 1'b1;
      else if (tc_clr)  tc_q   <= 1'b0;
    end
  end

endmodule

// File: rtl/dmac_core.sv
module dmac_core
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [2:0]        cpu_ofs,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic [BYTE_W-1:0] cpu_rdata,
  input  logic              cmd_wr,
  input  logic              mode_wr,
  input  logic              smask_wr,
  input  logic              amask_wr,
  input  logic              req_wr,
  input  logic              stat_rd,
  input  logic              mclr,
  input  logic              ptr_clr,
  input  logic              mask_clr,
  input  logic              xfer_req,
  input  logic [CHW-1:0]    xfer_chan,
  input  logic              xfer_is_wr,
  output logic [REG_W-1:0]  xfer_addr,
  output logic              xfer_na,
  output logic [BYTE_W-1:0] ctrl_cmd,
  output logic [NCH-1:0]    chan_mask,
  output logic [2*NCH-1:0]  chan_opm
);

  logic [CHW-1:0]   cpu_ch;
  logic             cpu_is_cnt;
  logic             ptr_hi;
  logic             reg_strobe;
  logic             type_ok;
  logic             xfer_accept;
  logic [REG_W-1:0] ch_addr [NCH];
  logic [REG_W-1:0] ch_cnt  [NCH];
  mode_t            ch_mode [NCH];
  logic [NCH-1:0]   req_vec, tc_vec, tc_hit_vec;
  logic [REG_W-1:0] sel_word;
  logic [BYTE_W-1:0] stat_byte;

  assign cpu_ch     = cpu_ofs[2:1];
  assign cpu_is_cnt = cpu_ofs[0];

  assign reg_strobe = cpu_wr | cmd_wr | mode_wr | smask_wr | amask_wr |
                      req_wr | mclr | ptr_clr | mask_clr;

  dmac_byteptr ptr_i (
    .clk    (clk),
    .rst    (rst),
    .clr    (ptr_clr | mclr),
    .flip   (cpu_wr | cpu_rd),
    .ptr_hi (ptr_hi)
  );

  always_comb begin
    if (xfer_is_wr) type_ok = (ch_mode[xfer_chan].xt == XT_WRITE);
    else            type_ok = (ch_mode[xfer_chan].xt == XT_READ);
  end

  assign xfer_accept = xfer_req && !reg_strobe && type_ok;
  assign xfer_na     = !xfer_accept;
  assign xfer_addr   = xfer_accept ? ch_addr[xfer_chan] : '0;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel_cpu, sel_mode, mask_we, mask_d;

    assign sel_cpu  = cpu_wr && (cpu_ch == CHW'(i));
    assign sel_mode = cpu_wdata[CHW-1:0] == CHW'(i);
    assign mask_we  = amask_wr | (smask_wr & sel_mode);
    assign mask_d   = amask_wr ? cpu_wdata[i] : cpu_wdata[2];

    dmac_chan ch_i (
      .clk          (clk),
      .rst          (rst),
      .mclr         (mclr),
      .ld_addr      (sel_cpu && !cpu_is_cnt),
      .ld_cnt       (sel_cpu && cpu_is_cnt),
      .ld_hi        (ptr_hi),
      .wbyte        (cpu_wdata),
      .mode_we      (mode_wr && sel_mode),
      .mode_d       (mode_t'(cpu_wdata[BYTE_W-1:2])),
      .mask_we      (mask_we),
      .mask_d       (mask_d),
      .mask_all_clr (mask_clr),
      .req_we       (req_wr && sel_mode),
      .req_d        (cpu_wdata[2]),
      .tc_clr       (stat_rd),
      .step         (xfer_accept && (xfer_chan == CHW'(i))),
      .cur_addr     (ch_addr[i]),
      .cur_cnt      (ch_cnt[i]),
      .mode_q       (ch_mode[i]),
      .mask_q       (chan_mask[i]),
      .req_q        (req_vec[i]),
      .tc_q         (tc_vec[i]),
      .tc_hit       (tc_hit_vec[i])
    );

    assign chan_opm[2*i +: 2] = ch_mode[i].opm;
  end

  always_ff @(posedge clk) begin
    if (rst)         ctrl_cmd <= '0;
    else if (cmd_wr) ctrl_cmd <= cpu_wdata;
  end

  assign sel_word  = cpu_is_cnt ? ch_cnt[cpu_ch] : ch_addr[cpu_ch];
  assign stat_byte = {req_vec, tc_vec};

  always_comb begin
    if (stat_rd)     cpu_rdata = stat_byte;
    else if (cpu_rd) cpu_rdata = byte_pick(sel_word, ptr_hi);
    else             cpu_rdata = '0;
  end

endmodule

// File: rtl/dmac_core_chk.sv
module dmac_core_chk
  import dmac_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic              ptr_clr,
  input logic              mclr,
  input logic              mask_clr,
  input logic              smask_wr,
  input logic              amask_wr,
  input logic              stat_rd,
  input logic              cmd_wr,
  input logic [BYTE_W-1:0] cpu_wdata,
  input logic [BYTE_W-1:0] ctrl_cmd,
  input logic              ptr_hi,
  input logic [NCH-1:0]    chan_mask,
  input logic [NCH-1:0]    req_vec,
  input logic [NCH-1:0]    tc_vec,
  input logic [NCH-1:0]    tc_hit_vec,
  input logic              reg_strobe,
  input logic              xfer_na
);

  // R1
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr || cpu_rd) && !ptr_clr && !mclr |=> ptr_hi != $past(ptr_hi));

  // R1
  ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr_clr || mclr) |=> !ptr_hi);

  // R9
  mclr_state_chk: assert property (@(posedge clk) disable iff (rst)
    mclr |=> (chan_mask == '1) && (req_vec == '0) && (tc_vec == '1));

  // R3
  mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
    mask_clr && !mclr && !smask_wr && !amask_wr |=> chan_mask == '0);

  // R7
  stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd && !mclr |=> tc_vec == $past(tc_hit_vec));

  // R7
  single_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tc_hit_vec));

  // R11
  strobe_block_chk: assert property (@(posedge clk) disable iff (rst)
    reg_strobe |-> xfer_na);

  // R10
  cmd_load_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> ctrl_cmd == $past(cpu_wdata));

endmodule

bind dmac_core dmac_core_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .cpu_wr     (cpu_wr),
  .cpu_rd     (cpu_rd),
  .ptr_clr    (ptr_clr),
  .mclr       (mclr),
  .mask_clr   (mask_clr),
  .smask_wr   (smask_wr),
  .amask_wr   (amask_wr),
  .stat_rd    (stat_rd),
  .cmd_wr     (cmd_wr),
  .cpu_wdata  (cpu_wdata),
  .ctrl_cmd   (ctrl_cmd),
  .ptr_hi     (ptr_hi),
  .chan_mask  (chan_mask),
  .req_vec    (req_vec),
  .tc_vec     (tc_vec),
  .tc_hit_vec (tc_hit_vec),
  .reg_strobe (reg_strobe),
  .xfer_na    (xfer_na)
);

// File: tb/dmac_core_tb_top.sv
module dmac_core_tb_top;

  localparam int K_WR = 0, K_RD = 1, K_STAT = 2, K_MODE = 3, K_SMASK = 4,
                 K_AMASK = 5, K_REQ = 6, K_CMD = 7, K_PCLR = 8, K_MCLR = 9,
                 K_MASKCLR = 10, K_NONE = 11;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst;
  logic        cpu_wr, cpu_rd, cmd_wr, mode_wr, smask_wr, amask_wr, req_wr;
  logic        stat_rd, mclr, ptr_clr, mask_clr, xfer_req, xfer_is_wr, xfer_na;
  logic [2:0]  cpu_ofs;
  logic [7:0]  cpu_wdata, cpu_rdata, ctrl_cmd, chan_opm;
  logic [1:0]  xfer_chan;
  logic [15:0] xfer_addr;
  logic [3:0]  chan_mask;

  dmac_core dut_i (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_ofs(cpu_ofs),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cmd_wr(cmd_wr),
    .mode_wr(mode_wr), .smask_wr(smask_wr), .amask_wr(amask_wr),
    .req_wr(req_wr), .stat_rd(stat_rd), .mclr(mclr), .ptr_clr(ptr_clr),
    .mask_clr(mask_clr), .xfer_req(xfer_req), .xfer_chan(xfer_chan),
    .xfer_is_wr(xfer_is_wr), .xfer_addr(xfer_addr), .xfer_na(xfer_na),
    .ctrl_cmd(ctrl_cmd), .chan_mask(chan_mask), .chan_opm(chan_opm)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  logic [15:0] m_addr [4], m_cnt [4], m_baddr [4], m_bcnt [4];
  logic [1:0]  m_xt [4], m_opm [4];
  logic        m_ai [4], m_dec [4];
  logic [3:0]  m_mask, m_req, m_tc;
  logic        m_ptr;
  logic [7:0]  m_cmd;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    {cpu_wr, cpu_rd, cmd_wr, mode_wr, smask_wr, amask_wr, req_wr} = '0;
    {stat_rd, mclr, ptr_clr, mask_clr, xfer_req, xfer_is_wr} = '0;
    cpu_ofs = '0; cpu_wdata = '0; xfer_chan = '0;
  endtask

  function automatic logic [7:0] half(input logic [15:0] w, input logic hi);
    return 8'((w >> (hi ? 8 : 0)) & 16'h00ff);
  endfunction

  function automatic logic [15:0] put(input logic [15:0] w, input logic hi, input logic [7:0] b);
    return hi ? ((w & 16'h00ff) | (16'(b) << 8)) : ((w & 16'hff00) | 16'(b));
  endfunction

  task automatic m_clear(input bit full);
    m_ptr = 0; m_mask = 4'hf; m_tc = 4'hf; m_req = 4'h0;
    if (full) begin
      m_cmd = 0;
      for (int i = 0; i < 4; i++) begin
        m_addr[i] = 0; m_cnt[i] = 0; m_baddr[i] = 0; m_bcnt[i] = 0;
        m_xt[i] = 0; m_opm[i] = 0; m_ai[i] = 0; m_dec[i] = 0;
      end
    end
  endtask

  task automatic m_step(input int c);
    if (m_cnt[c] == 16'h0000) begin
      m_tc[c] = 1'b1;
      if (m_ai[c]) begin
        m_addr[c] = m_baddr[c]; m_cnt[c] = m_bcnt[c];
        return;
      end
    end
    m_addr[c] = m_dec[c] ? m_addr[c] + 16'hffff : m_addr[c] + 16'h0001;
    m_cnt[c] = m_cnt[c] + 16'hffff;
  endtask

  task automatic op(input int kind, input logic [7:0] d, input logic [2:0] ofs,
                    input logic xq, input logic [1:0] xc, input logic xw);
    bit strobe, acc;
    int ch;
    @(negedge clk);
    quiet();
    case (kind)
      K_WR: cpu_wr = 1;       K_RD: cpu_rd = 1;       K_STAT: stat_rd = 1;
      K_MODE: mode_wr = 1;    K_SMASK: smask_wr = 1;  K_AMASK: amask_wr = 1;
      K_REQ: req_wr = 1;      K_CMD: cmd_wr = 1;      K_PCLR: ptr_clr = 1;
      K_MCLR: mclr = 1;       K_MASKCLR: mask_clr = 1; default: ;
    endcase
    cpu_ofs = ofs; cpu_wdata = d;
    xfer_req = xq; xfer_chan = xc; xfer_is_wr = xw;
    #2;
    ch = int'(ofs >> 1);
    strobe = !(kind == K_RD || kind == K_STAT || kind == K_NONE);
    acc = xq && !strobe && (m_xt[xc] == (xw ? 2'd1 : 2'd2));
    if (xq && strobe) check("R11 strobe blocks transfer", xfer_na, 1);
    else              check("R5 type gate", xfer_na, !acc);
    if (acc) check("R6 transfer address", xfer_addr, m_addr[xc]);
    else     check("R5 idle address", xfer_addr, 0);
    if (kind == K_RD)
      check("R1 byte read", cpu_rdata, half(ofs[0] ? m_cnt[ch] : m_addr[ch], m_ptr));
    if (kind == K_STAT) check("R7 R4 status", cpu_rdata, {m_req, m_tc});
    @(posedge clk);
    case (kind)
      K_WR: begin
        if (ofs[0]) begin m_cnt[ch] = put(m_cnt[ch], m_ptr, d); m_bcnt[ch] = m_cnt[ch]; end
        else begin m_addr[ch] = put(m_addr[ch], m_ptr, d); m_baddr[ch] = m_addr[ch]; end
        m_ptr = ~m_ptr;
      end
      K_RD: m_ptr = ~m_ptr;
      K_STAT: m_tc = 0;
      K_MODE: begin
        m_xt[d[1:0]] = d[3:2]; m_ai[d[1:0]] = d[4];
        m_dec[d[1:0]] = d[5]; m_opm[d[1:0]] = d[7:6];
      end
      K_SMASK: m_mask[d[1:0]] = d[2];
      K_AMASK: m_mask = d[3:0];
      K_REQ: m_req[d[1:0]] = d[2];
      K_CMD: m_cmd = d;
      K_PCLR: m_ptr = 0;
      K_MCLR: m_clear(0);
      K_MASKCLR: m_mask = 0;
      default: ;
    endcase
    if (acc) m_step(xc);
    #1;
    if (kind == K_SMASK || kind == K_AMASK || kind == K_MASKCLR)
      check("R3 mask", chan_mask, m_mask);
    if (kind == K_MCLR) check("R9 master clear mask", chan_mask, m_mask);
    if (kind == K_CMD) check("R10 command", ctrl_cmd, m_cmd);
    if (kind == K_MODE)
      check("R5 operating mode", chan_opm, {m_opm[3], m_opm[2], m_opm[1], m_opm[0]});
    quiet();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d3a_5eed));
    quiet();
    rst = 1;
    m_clear(1);
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    #2;
    check("R9 reset mask", chan_mask, 4'hf);
    check("R9 reset command", ctrl_cmd, 0);
    op(K_STAT, 0, 0, 0, 0, 0);                 // R9 R7: tc all set after reset
    // R1 R6 R7: channel 0 read transfers, increment, count 2
    op(K_WR, 8'h34, 3'b000, 0, 0, 0);
    op(K_WR, 8'h12, 3'b000, 0, 0, 0);
    op(K_WR, 8'h02, 3'b001, 0, 0, 0);
    op(K_WR, 8'h00, 3'b001, 0, 0, 0);
    op(K_MODE, 8'h08, 0, 0, 0, 0);
    op(K_NONE, 0, 0, 1, 0, 1);                 // R5 wrong direction
    op(K_NONE, 0, 0, 1, 0, 0);
    op(K_NONE, 0, 0, 1, 0, 0);
    op(K_STAT, 0, 0, 1, 0, 0);                 // R7 wrap while reading status
    op(K_STAT, 0, 0, 0, 0, 0);
    op(K_RD, 0, 3'b001, 0, 0, 0);              // R1 count low after wrap
    op(K_RD, 0, 3'b001, 0, 0, 0);
    // R8: channel 1 autoinit, decrement, write, count 1
    op(K_PCLR, 0, 0, 0, 0, 0);
    op(K_WR, 8'h00, 3'b010, 0, 0, 0);
    op(K_WR, 8'h80, 3'b010, 0, 0, 0);
    op(K_WR, 8'h01, 3'b011, 0, 0, 0);
    op(K_WR, 8'h00, 3'b011, 0, 0, 0);
    op(K_MODE, 8'h75, 0, 0, 0, 0);
    for (int k = 0; k < 5; k++) op(K_NONE, 0, 0, 1, 1, 1);
    op(K_CMD, 8'ha5, 0, 1, 1, 1);              // R11 R10
    op(K_REQ, 8'h06, 0, 0, 0, 0);              // R4
    op(K_SMASK, 8'h01, 0, 0, 0, 0);            // R3
    op(K_MASKCLR, 0, 0, 0, 0, 0);
    op(K_AMASK, 8'h0a, 0, 0, 0, 0);
    op(K_STAT, 0, 0, 0, 0, 0);
    op(K_MCLR, 0, 0, 1, 1, 1);                 // R9
    op(K_STAT, 0, 0, 0, 0, 0);
    op(K_RD, 0, 3'b010, 0, 0, 0);              // R2 address kept over master clear

    for (int it = 0; it < 4000; it++) begin
      int kind;
      logic [7:0] d;
      logic [2:0] ofs;
      logic xq;
      kind = $urandom_range(0, 17);
      if (kind > K_NONE) kind = K_NONE;
      if (kind == K_MCLR && $urandom_range(0, 9) != 0) kind = K_RD;
      ofs = 3'($urandom_range(0, 7));
      d = 8'($urandom);
      if (kind == K_WR && ofs[0] && $urandom_range(0, 1) == 1) d = 8'($urandom_range(0, 3));
      xq = (kind == K_NONE) || ($urandom_range(0, 3) == 0);
      op(kind, d, ofs, xq, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule